// File: doc/BRIEF.md
# Periodic Pulse and Interrupt Generator

This block turns one of four period strobes from a clock counter into a timing event on an active-low flag output. The strobes stand for 1/64 s, 1 s, 1 minute and 1 hour. Each event raises a host-readable event flag and asks the pin driver to pull the line low.

A configuration write sets three things: a mask bit, a mode bit and a two-bit period select. In pulse mode the low level ends by itself after a fixed number of prescaler ticks. In interrupt mode the low level lasts until the host writes 0 to the flag. While the flag is still set, any new event is dropped.

A new period or mode waits until the first strobe of the newly selected period. That strobe becomes the first event under the new settings, so a change never produces a stray edge. The mask bit acts on the cycle after its write.

Top module: `tick_irq_gen`

## Requirements
- R1: After reset the flag is 0, the pin is released, the mask is 1, the mode is pulse (mode bit 0) and the period select is 0.
- R2: Period select value s picks strobe bit s of `rate_stb`: 0 = 1/64 s, 1 = 1 s, 2 = 1 minute, 3 = 1 hour. Strobes on the other bits cause no event.
- R3: While the mask is 1, no event sets the flag, and the pin stays released even if the flag is already set.
- R4: In pulse mode (mode bit 0), an accepted event sets the flag and pulls the pin low on the next cycle. Both clear on the cycle after the PULSE_TICKS-th `tick_stb` that follows the event cycle.
- R5: In interrupt mode (mode bit 1), the flag and the low pin persist, whatever the ticks, until a flag write with data 0.
- R6: An event that arrives while the flag is set is lost. It does not restart the pulse width and does not change the flag.
- R7: A flag write with data 1 has no effect on the flag or the pin.
- R8: A written period select and mode stay pending until the first strobe of the newly selected period. That strobe is the first event under the new settings. Strobes of the old period are ignored in the meantime.
- R9: When an accepted event and a flag write of 0 fall in the same cycle, the event wins. When the flag was already set, the write clears it and the event is lost.
- R10: A mask write takes effect on the next cycle, independent of any pending period or mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_stb | input | 4 | One-cycle period strobes, bit s for select value s |
| tick_stb | input | 1 | Prescaler tick that times the pulse width |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mask | input | 1 | Mask bit to write (1 = suppress) |
| cfg_irq_mode | input | 1 | Mode bit to write (0 pulse, 1 interrupt) |
| cfg_rate | input | 2 | Period select to write |
| flag_we | input | 1 | Event flag write strobe |
| flag_wdata | input | 1 | Event flag write data (only 0 acts) |
| pin_pull_low | output | 1 | 1 = drive the pin low, 0 = release it |
| irq_flag | output | 1 | Readable event flag |

## Verification
The bench builds the block with PULSE_TICKS = 3. This keeps a full pulse short enough that random strobes often land inside a held pulse, which exercises the lost-event path, while a mid-pulse strobe can still be placed between ticks. The random phase uses frequent ticks and rare configuration writes. As a result, pending changes overlap held flags, masking and same-cycle clears, and a bench reference model predicts the flag and pin every cycle.

// File: rtl/tick_irq_pkg.sv
`timescale 1ns/1ps
package tick_irq_pkg;
  localparam int RSEL_W    = 2;
  localparam int NUM_RATES = 1 << RSEL_W;

  typedef enum logic {MODE_PULSE = 1'b0, MODE_IRQ = 1'b1} irq_mode_e;

  typedef struct packed {
    irq_mode_e         mode;
    logic [RSEL_W-1:0] rate;
  } period_cfg_t;

  // Next flag value: a new event beats a clear or an automatic release.
  function automatic logic flag_next(logic cur, logic accept, logic clear, logic release_now);
    if (accept) return 1'b1;
    if (clear || release_now) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/tick_irq_cfg.sv
`timescale 1ns/1ps
module tick_irq_cfg
  import tick_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RATES-1:0] rate_stb,
  input  logic                 cfg_we,
  input  logic                 cfg_mask,
  input  irq_mode_e            cfg_mode,
  input  logic [RSEL_W-1:0]    cfg_rate,
  output logic                 mask_q,
  output logic                 event_stb,
  output irq_mode_e            act_mode
);
  period_cfg_t act_q, pend_q, eff;
  logic        pend_v_q;
  logic [NUM_RATES-1:0] hit;
  logic        apply;

  // While a change is pending, only the new period can produce an event.
  assign eff = pend_v_q ? pend_q : act_q;

  for (genvar i = 0; i < NUM_RATES; i++) begin : g_rate
    assign hit[i] = rate_stb[i] && (eff.rate == RSEL_W'(i));
  end

  assign event_stb = |hit;
  assign apply     = pend_v_q && event_stb;
  assign act_mode  = act_q.mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= 1'b1;
      act_q    <= '{mode: MODE_PULSE, rate: '0};
      pend_q   <= '{mode: MODE_PULSE, rate: '0};
      pend_v_q <= 1'b0;
    end else begin
      if (apply) act_q <= pend_q;
      if (cfg_we) begin
        mask_q   <= cfg_mask;
        pend_q   <= '{mode: cfg_mode, rate: cfg_rate};
        pend_v_q <= 1'b1;
      end else if (apply) begin
        pend_v_q <= 1'b0;
      end
    end
  end

  p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v_q && !event_stb && !cfg_we) |=> (pend_v_q && $stable(act_q)));

  p_apply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v_q && event_stb) |=> (act_q == $past(pend_q)));

  p_mask_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (mask_q == $past(cfg_mask)));
endmodule

// File: rtl/tick_irq_flag.sv
`timescale 1ns/1ps
module tick_irq_flag
  import tick_irq_pkg::*;
#(
  parameter int PULSE_TICKS = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      event_stb,
  input  logic      mask_q,
  input  irq_mode_e act_mode,
  input  logic      tick_stb,
  input  logic      flag_we,
  input  logic      flag_wdata,
  output logic      held_q,
  output logic      accept,
  output logic      auto_rel
);
  localparam int CNT_W = $clog2(PULSE_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic             dec, clear;

  assign clear    = flag_we && !flag_wdata;
  assign accept   = event_stb && !held_q && !mask_q;
  assign dec      = held_q && (act_mode == MODE_PULSE) && tick_stb && (cnt_q != '0);
  assign auto_rel = dec && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      held_q <= flag_next(held_q, accept, clear, auto_rel);
      if (accept)   cnt_q <= CNT_LOAD;
      else if (dec) cnt_q <= cnt_q - 1'b1;
    end
  end

  p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (held_q && cnt_q == CNT_LOAD));

  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LOAD);

  p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && act_mode == MODE_IRQ && !clear) |=> held_q);

  p_no_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && event_stb) |=> (cnt_q <= $past(cnt_q)));

  p_w1_noop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && flag_wdata && !held_q && !accept) |=> !held_q);
endmodule

// File: rtl/tick_irq_gen.sv
`timescale 1ns/1ps
module tick_irq_gen
  import tick_irq_pkg::*;
#(
  parameter int PULSE_TICKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RATES-1:0] rate_stb,
  input  logic                 tick_stb,
  input  logic                 cfg_we,
  input  logic                 cfg_mask,
  input  logic                 cfg_irq_mode,
  input  logic [RSEL_W-1:0]    cfg_rate,
  input  logic                 flag_we,
  input  logic                 flag_wdata,
  output logic                 pin_pull_low,
  output logic                 irq_flag
);
  logic      mask_q, event_stb, held_q, accept, auto_rel;
  irq_mode_e act_mode;

  tick_irq_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_stb  (rate_stb),
    .cfg_we    (cfg_we),
    .cfg_mask  (cfg_mask),
    .cfg_mode  (irq_mode_e'(cfg_irq_mode)),
    .cfg_rate  (cfg_rate),
    .mask_q    (mask_q),
    .event_stb (event_stb),
    .act_mode  (act_mode)
  );

  tick_irq_flag #(.PULSE_TICKS(PULSE_TICKS)) u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .event_stb  (event_stb),
    .mask_q     (mask_q),
    .act_mode   (act_mode),
    .tick_stb   (tick_stb),
    .flag_we    (flag_we),
    .flag_wdata (flag_wdata),
    .held_q     (held_q),
    .accept     (accept),
    .auto_rel   (auto_rel)
  );

  assign irq_flag     = held_q;
  assign pin_pull_low = held_q && !mask_q;

  p_mask_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q && !irq_flag) |=> !irq_flag);

  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && flag_we && !flag_wdata) |=> irq_flag);

  p_rel_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rel && !accept) |=> !irq_flag);
endmodule

// File: tb/tick_irq_gen_bench.sv
`timescale 1ns/1ps
module tick_irq_gen_bench;
  localparam int PT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] rate_stb = '0;
  logic       tick_stb = 1'b0, cfg_we = 1'b0, cfg_mask = 1'b0, cfg_irq_mode = 1'b0;
  logic [1:0] cfg_rate = '0;
  logic       flag_we = 1'b0, flag_wdata = 1'b0;
  logic       pin_pull_low, irq_flag;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  bit       m_flag, m_mask, ma_mode, mp_mode, mp_v;
  bit [1:0] ma_rate, mp_rate;
  int       m_cnt;

  tick_irq_gen #(.PULSE_TICKS(PT)) u_tick_irq_gen (
    .clk(clk), .rst_n(rst_n), .rate_stb(rate_stb), .tick_stb(tick_stb),
    .cfg_we(cfg_we), .cfg_mask(cfg_mask), .cfg_irq_mode(cfg_irq_mode), .cfg_rate(cfg_rate),
    .flag_we(flag_we), .flag_wdata(flag_wdata), .pin_pull_low(pin_pull_low), .irq_flag(irq_flag)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit sel_hit(bit [3:0] stb, bit [1:0] r);
    return stb[r];
  endfunction

  // One clock: predict from the requirements, advance, compare, drop one-shot inputs.
  task automatic step(input string tag);
    bit [1:0] er;
    bit fire, acc, rel, clr, nf;
    int nc;
    er   = mp_v ? mp_rate : ma_rate;
    fire = sel_hit(rate_stb, er);
    acc  = fire && !m_flag && !m_mask;
    rel  = m_flag && !ma_mode && tick_stb && (m_cnt == 1);
    clr  = flag_we && !flag_wdata;
    nf   = acc ? 1'b1 : ((clr || rel) ? 1'b0 : m_flag);
    nc   = acc ? PT : ((m_flag && !ma_mode && tick_stb && m_cnt != 0) ? m_cnt - 1 : m_cnt);
    @(posedge clk);
    #1;
    if (fire && mp_v) begin ma_mode = mp_mode; ma_rate = mp_rate; end
    if (cfg_we) begin
      m_mask = cfg_mask; mp_mode = cfg_irq_mode; mp_rate = cfg_rate; mp_v = 1;
    end else if (fire && mp_v) mp_v = 0;
    m_flag = nf;
    m_cnt  = nc;
    check(irq_flag == m_flag, {tag, " flag"}, irq_flag, m_flag);
    check(pin_pull_low == (m_flag && !m_mask), {tag, " pin"}, pin_pull_low, m_flag && !m_mask);
    rate_stb = '0; tick_stb = 0; cfg_we = 0; flag_we = 0;
  endtask

  task automatic expect_out(input bit f, input bit p, input string tag);
    check(irq_flag == f, {tag, " flag literal"}, irq_flag, f);
    check(pin_pull_low == p, {tag, " pin literal"}, pin_pull_low, p);
  endtask

  task automatic wr_cfg(input bit mask, input bit mode, input bit [1:0] r, input string tag);
    cfg_we = 1; cfg_mask = mask; cfg_irq_mode = mode; cfg_rate = r;
    step(tag);
  endtask

  task automatic wr_flag(input bit d, input string tag);
    flag_we = 1; flag_wdata = d;
    step(tag);
  endtask

  task automatic strobe(input bit [3:0] s, input string tag);
    rate_stb = s;
    step(tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_flag = 0; m_mask = 1; ma_mode = 0; mp_mode = 0; mp_v = 0;
    ma_rate = 0; mp_rate = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    expect_out(0, 0, "R1 reset");

    // R1/R3: masked out of reset, every strobe ignored
    strobe(4'hF, "R3");
    expect_out(0, 0, "R1 masked after reset");

    // R8: pending rate 1, old rate 0 ignored
    wr_cfg(0, 0, 2'd1, "R10");
    strobe(4'b0001, "R8");
    expect_out(0, 0, "R8 old rate ignored");
    strobe(4'b0010, "R8");
    expect_out(1, 1, "R8 first event");

    // R4 / R6: 3 ticks, a lost event in the middle
    tick_stb = 1; step("R4");
    expect_out(1, 1, "R4 tick1");
    strobe(4'b0010, "R6");
    expect_out(1, 1, "R6 lost event");
    tick_stb = 1; step("R4");
    expect_out(1, 1, "R4 tick2");
    tick_stb = 1; step("R4");
    expect_out(0, 0, "R4 released after PT ticks");

    // R5 / R7: interrupt mode, period 2
    wr_cfg(0, 1, 2'd2, "R8");
    strobe(4'b0100, "R5");
    expect_out(1, 1, "R5 set");
    for (int i = 0; i < 8; i++) begin tick_stb = 1; step("R5"); end
    expect_out(1, 1, "R5 held over ticks");
    wr_flag(1, "R7");
    expect_out(1, 1, "R7 write 1 no effect");
    wr_flag(0, "R5");
    expect_out(0, 0, "R5 cleared by write 0");
    wr_flag(1, "R7");
    expect_out(0, 0, "R7 write 1 does not set");

    // R9
    rate_stb = 4'b0100; flag_we = 1; flag_wdata = 0; step("R9");
    expect_out(1, 1, "R9 event wins over clear");
    rate_stb = 4'b0100; flag_we = 1; flag_wdata = 0; step("R9");
    expect_out(0, 0, "R9 held: clear wins, event lost");

    // R3 / R10: mask while held
    strobe(4'b0100, "R3");
    wr_cfg(1, 1, 2'd2, "R10");
    expect_out(1, 0, "R3 mask releases pin");
    wr_flag(0, "R3");
    strobe(4'b0100, "R3");
    expect_out(0, 0, "R3 masked event ignored");

    // R2: each period select
    for (int r = 0; r < 4; r++) begin
      wr_cfg(0, 1, 2'(r), "R2");
      strobe(4'(1 << r), "R2");
      wr_flag(0, "R2");
      strobe(~4'(1 << r), "R2");
      expect_out(0, 0, "R2 other strobes ignored");
      strobe(4'(1 << r), "R2");
      expect_out(1, 1, "R2 selected strobe");
      wr_flag(0, "R2");
    end

    // random mix
    for (int n = 0; n < 4000; n++) begin
      for (int b = 0; b < 4; b++) rate_stb[b] = ($urandom % 12) == 0;
      tick_stb = ($urandom % 3) == 0;
      if (($urandom % 40) == 0) begin
        cfg_we = 1; cfg_mask = ($urandom % 5) == 0;
        cfg_irq_mode = $urandom % 2; cfg_rate = 2'($urandom % 4);
      end
      if (($urandom % 10) == 0) begin flag_we = 1; flag_wdata = $urandom % 2; end
      step("R6 random");
    end

    done = 1;
    finish_run();
  end
endmodule